// File: doc/BRIEF.md
# Constant-Carry Split Adder with Saturating Low Segment

This combinational block adds two W-bit unsigned operands and returns a (W+1)-bit result. The operands are split at bit H. The upper W-H bits are added by an ordinary adder whose carry-in is a constant, so the carry out of the lower H bits never reaches the upper segment. This removes the long carry path between the two segments. The result is approximate, and its worst-case error is bounded by the weight of bit H.

The lower H bits still form their own sum and carry-out. That carry is no longer passed upward. It is used only to bound the lower sum bits. In the underestimating variant (OVER=0) the upper carry-in is 0. Whenever the lost carry is 1, every lower sum bit is forced to 1. In the overestimating variant (OVER=1) the upper carry-in is 1. Whenever the true lower carry is 0, every lower sum bit is forced to 0. As a result, errors are always negative in the first variant and always positive in the second. Setting EXACT=1 restores the true carry into the upper segment and disables bounding, which gives an exact adder for comparison. H must lie between 1 and W-1.

Top module: `fixcarry_bound_adder`

## Requirements
- R1: With EXACT=1, sum_o equals a_i + b_i for every operand pair.
- R2: The bits sum_o[W:H] always equal a_i[W-1:H] + b_i[W-1:H] + K, zero-extended to W-H+1 bits. K is OVER when EXACT=0 and the true lower carry when EXACT=1. The top bit sum_o[W] is the upper adder's carry-out.
- R3: With EXACT=0 and OVER=0, if a_i[H-1:0] + b_i[H-1:0] < 2^H, then sum_o equals a_i + b_i.
- R4: With EXACT=0 and OVER=0, if a_i[H-1:0] + b_i[H-1:0] >= 2^H, then sum_o[H-1:0] is all ones. In that case a_i + b_i - sum_o equals L + 1, where L is (a_i[H-1:0] + b_i[H-1:0]) mod 2^H. The error is therefore negative and smaller than 2^H in magnitude.
- R5: With EXACT=0 and OVER=1, if a_i[H-1:0] + b_i[H-1:0] >= 2^H, then sum_o equals a_i + b_i.
- R6: With EXACT=0 and OVER=1, if a_i[H-1:0] + b_i[H-1:0] < 2^H, then sum_o[H-1:0] is all zeros. In that case sum_o - (a_i + b_i) equals 2^H - L. The error is therefore positive and at most 2^H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand, unsigned |
| b_i | input | W | Second operand, unsigned |
| sum_o | output | W+1 | Approximate (or exact) sum |

## Verification
The bench builds three copies with W=8 and H=3: one exact, one underestimating and one overestimating. All three receive the same operands. An 8-bit width allows every one of the 65,536 operand pairs to be applied. This covers every lower-carry case, every value of the lower residue L, and the carry-out of the upper adder at the top bit. A 3-bit low segment makes the error bounds (at most 7 below the true sum, at most 8 above it) small enough to check exactly for each pair.

// File: rtl/fixcarry_bound_adder.sv
module fixcarry_bound_adder #(
  parameter int W     = 16,
  parameter int H     = 6,
  parameter bit OVER  = 1'b0,
  parameter bit EXACT = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   sum_o
);
  localparam int HW = W - H;
  localparam logic [W:0] SPAN = {{W{1'b0}}, 1'b1} << H;

  logic [H:0]   lo_sum;
  logic         lo_cy;
  logic         hi_cin;
  logic [HW:0]  hi_sum;
  logic [H-1:0] lo_out;

  assign lo_sum = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]};
  assign lo_cy  = lo_sum[H];
  assign hi_cin = EXACT ? lo_cy : OVER;
  assign hi_sum = {1'b0, a_i[W-1:H]} + {1'b0, b_i[W-1:H]} + {{HW{1'b0}}, hi_cin};

  generate
    if (EXACT) begin : g_exact
      assign lo_out = lo_sum[H-1:0];
    end else if (OVER) begin : g_over
      assign lo_out = lo_sum[H-1:0] & {H{lo_cy}};
    end else begin : g_under
      assign lo_out = lo_sum[H-1:0] | {H{lo_cy}};
    end
  endgenerate

  assign sum_o = {hi_sum, lo_out};

  logic [W:0] chk_full;
  assign chk_full = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    if (EXACT)
      p_exact_r1: assert (sum_o == chk_full);
    if (!EXACT && !OVER) begin
      if (!lo_cy)
        p_no_loss_r3: assert (sum_o == chk_full);
      p_under_bound_r4: assert (sum_o <= chk_full && (chk_full - sum_o) < SPAN);
    end
    if (!EXACT && OVER) begin
      if (lo_cy)
        p_no_gain_r5: assert (sum_o == chk_full);
      p_over_bound_r6: assert (sum_o >= chk_full && (sum_o - chk_full) <= SPAN);
    end
  end
endmodule

// File: tb/fixcarry_bound_adder_tb_top.sv
module fixcarry_bound_adder_tb_top;
  localparam int W = 8;
  localparam int H = 3;
  localparam int M = 1 << H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b;
  logic [W:0] s_exact, s_under, s_over;
  int n_chk = 0, n_fail = 0;
  int wd = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fixcarry_bound_adder #(.W(W), .H(H), .OVER(1'b0), .EXACT(1'b1)) dut_exact_i (.a_i(a), .b_i(b), .sum_o(s_exact));
  fixcarry_bound_adder #(.W(W), .H(H), .OVER(1'b0), .EXACT(1'b0)) dut_i       (.a_i(a), .b_i(b), .sum_o(s_under));
  fixcarry_bound_adder #(.W(W), .H(H), .OVER(1'b1), .EXACT(1'b0)) dut_over_i  (.a_i(a), .b_i(b), .sum_o(s_over));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000 && !done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 zero", int'(s_exact), 0);
    check("R3 zero", int'(s_under), 0);
    check("R6 zero", int'(s_over), M);
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        @(posedge clk);
        a = W'(i);
        b = W'(j);
        @(negedge clk);
        begin
          int full, lo, l, cy, hi;
          full = i + j;
          lo   = (i % M) + (j % M);
          l    = lo % M;
          cy   = (lo >= M) ? 1 : 0;
          hi   = (i / M) + (j / M);
          check("R1", int'(s_exact), full);
          check("R2 exact upper", int'(s_exact) / M, hi + cy);
          check("R2 under upper", int'(s_under) / M, hi);
          check("R2 over upper", int'(s_over) / M, hi + 1);
          if (cy == 0) begin
            check("R3", int'(s_under), full);
            check("R6 low zero", int'(s_over) % M, 0);
            check("R6 error", int'(s_over) - full, M - l);
          end else begin
            check("R4 low ones", int'(s_under) % M, M - 1);
            check("R4 error", full - int'(s_under), l + 1);
            check("R5", int'(s_over), full);
          end
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule